// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates a bank of Boolean functions written as sums of products. Each logic input enters the array twice, once as itself and once inverted. A programmable AND plane of connection bits combines any chosen set of these literals into each product term. An OR plane then merges the terms into each output. All connection bits live in registers and are written one row at a time through a parallel configuration port.

A mode input selects one of three architectures built from the same fabric. The first is a fully programmable two-plane array, in which a term may drive any number of outputs. The second has a hard-wired OR plane: each output owns its own disjoint slice of terms, and the OR connection bits are ignored. The third replaces the AND plane with a complete minterm decoder, so each OR row becomes the output's truth table, indexed by the input value.

The outputs are registered. While configuration loading is open, they are forced low. A new configuration is visible in the first output update after loading closes.

Top module: `sop_array`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_vec` is 0 and every connection bit is cleared.
- R2: AND row bit 2i connects input i and bit 2i+1 connects its inverse. A product term is the AND of its connected literals, and an unconnected crosspoint has no effect on it.
- R3: A product term whose AND row is all zero reads as 1 (default `EMPTY_ZERO`=0). Setting `EMPTY_ZERO`=1 forces such a term to 0.
- R4: In mode 0 (array), bit p of OR row m connects term p to output m. Output m is the OR of its connected terms, an unconnected crosspoint has no effect, and one term may feed several outputs.
- R5: In mode 1 (fixed OR), output m is the OR of terms m*G to m*G+G-1, where G = N_TERM/N_OUT. The OR rows have no effect.
- R6: In mode 2 (full decode), there are 2^N_IN terms and term k is 1 only when `in_vec` equals k. Output m equals bit `in_vec` of OR row m, so any truth table can be realised.
- R7: In mode 3, all outputs are 0.
- R8: When `cfg_load` and `cfg_we` are both high at a clock edge, `cfg_data` is written into row `cfg_row` of the plane named by `cfg_plane` (0 = AND, using the low 2*N_IN bits; 1 = OR). A row index beyond the plane's row count writes nothing.
- R9: `out_vec` after a clock edge reflects `in_vec`, `mode` and the configuration present before that edge. Any edge taken with `cfg_load` high yields 0, so a configuration written during loading first shows up on the edge after `cfg_load` falls.
- R10: `cfg_we` has no effect while `cfg_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Architecture select: 0 array, 1 fixed OR, 2 full decode, 3 off |
| in_vec | input | N_IN | Logic inputs |
| cfg_load | input | 1 | Configuration window open; outputs held low |
| cfg_we | input | 1 | Row write strobe, only acted on inside the window |
| cfg_plane | input | 1 | Target plane: 0 AND, 1 OR |
| cfg_row | input | ROW_W | Row index within the target plane |
| cfg_data | input | CFG_W | Row contents |
| out_vec | output | N_OUT | Registered function outputs |

## Verification
On every cycle, the assertions check the following: outputs are low after any edge taken during loading, outputs are low in the off mode, the minterm decoder raises exactly one term, and outputs stay steady while inputs, mode and configuration stay still. Only the bench's scenarios can show that the logic is correct. It sweeps every input value in each mode against a behavioural model: literal polarity, term sharing between outputs, the fixed term grouping, empty terms reading 1, truth-table lookup, and writes that must be ignored (out-of-range rows and strobes outside the window).

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_OFF    = 2'd3
  } mode_e;

  // Literal vector: bit 2i is input i, bit 2i+1 its inverse.
  function automatic logic [63:0] expand_literals(input logic [31:0] in_bits, input int n);
    logic [63:0] lits;
    lits = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        lits[2*i]   = in_bits[i];
        lits[2*i+1] = ~in_bits[i];
      end
    end
    return lits;
  endfunction

  // AND of connected literals; an all-empty row gives 1 unless empty_zero.
  function automatic logic product_of(input logic [63:0] row, input logic [63:0] lits,
                                      input int width, input bit empty_zero);
    logic res;
    logic any;
    res = 1'b1;
    any = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < width && row[i]) begin
        any = 1'b1;
        if (!lits[i]) res = 1'b0;
      end
    end
    if (!any && empty_zero) res = 1'b0;
    return res;
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2,
  parameter int AND_W  = 8,
  parameter int OR_W   = 16,
  parameter int CFG_W  = 16,
  parameter int ROW_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_and,
  input  logic                    wr_or,
  input  logic [ROW_W-1:0]        row,
  input  logic [CFG_W-1:0]        data,
  output logic [N_TERM*AND_W-1:0] and_rows,
  output logic [N_OUT*OR_W-1:0]   or_rows
);

  logic [AND_W-1:0] and_q [N_TERM];
  logic [OR_W-1:0]  or_q  [N_OUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N_TERM; p++) and_q[p] <= '0;
      for (int m = 0; m < N_OUT; m++)  or_q[m]  <= '0;
    end else begin
      for (int p = 0; p < N_TERM; p++)
        if (wr_and && int'(row) == p) and_q[p] <= data[AND_W-1:0];
      for (int m = 0; m < N_OUT; m++)
        if (wr_or && int'(row) == m) or_q[m] <= data[OR_W-1:0];
    end
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_and_flat
    assign and_rows[p*AND_W +: AND_W] = and_q[p];
  end
  for (genvar m = 0; m < N_OUT; m++) begin : g_or_flat
    assign or_rows[m*OR_W +: OR_W] = or_q[m];
  end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN       = 4,
  parameter int N_TERM     = 8,
  parameter int EMPTY_ZERO = 0,
  localparam int AND_W     = 2 * N_IN,
  localparam int DEC_N     = 1 << N_IN
) (
  input  logic [N_IN-1:0]         in_vec,
  input  logic [N_TERM*AND_W-1:0] and_rows,
  output logic [N_TERM-1:0]       term_vec,
  output logic [DEC_N-1:0]        minterm_vec
);

  logic [63:0] lits;
  assign lits = sop_pkg::expand_literals(32'(in_vec), N_IN);

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    assign term_vec[p] = sop_pkg::product_of(64'(and_rows[p*AND_W +: AND_W]), lits,
                                             AND_W, EMPTY_ZERO != 0);
  end

  for (genvar k = 0; k < DEC_N; k++) begin : g_minterm
    assign minterm_vec[k] = (in_vec == N_IN'(k));
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2,
  parameter int DEC_N  = 16,
  parameter int OR_W   = 16,
  localparam int GRP   = N_TERM / N_OUT
) (
  input  sop_pkg::mode_e         mode,
  input  logic [N_TERM-1:0]      term_vec,
  input  logic [DEC_N-1:0]       minterm_vec,
  input  logic [N_OUT*OR_W-1:0]  or_rows,
  output logic [N_OUT-1:0]       sum_vec
);

  for (genvar m = 0; m < N_OUT; m++) begin : g_out
    logic [OR_W-1:0] row;
    logic arr_s, fix_s, dec_s;
    assign row   = or_rows[m*OR_W +: OR_W];
    assign arr_s = |(row[N_TERM-1:0] & term_vec);
    assign fix_s = |term_vec[m*GRP +: GRP];
    assign dec_s = |(row[DEC_N-1:0] & minterm_vec);
    always_comb begin
      case (mode)
        sop_pkg::MODE_ARRAY:  sum_vec[m] = arr_s;
        sop_pkg::MODE_FIXED:  sum_vec[m] = fix_s;
        sop_pkg::MODE_DECODE: sum_vec[m] = dec_s;
        default:              sum_vec[m] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN       = 4,
  parameter int N_TERM     = 8,
  parameter int N_OUT      = 2,
  parameter int EMPTY_ZERO = 0,
  localparam int AND_W     = 2 * N_IN,
  localparam int DEC_N     = 1 << N_IN,
  localparam int OR_W      = (N_TERM > DEC_N) ? N_TERM : DEC_N,
  localparam int CFG_W     = (AND_W > OR_W) ? AND_W : OR_W,
  localparam int ROWS      = (N_TERM > N_OUT) ? N_TERM : N_OUT,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [N_IN-1:0]  in_vec,
  input  logic             cfg_load,
  input  logic             cfg_we,
  input  logic             cfg_plane,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic [CFG_W-1:0] cfg_data,
  output logic [N_OUT-1:0] out_vec
);

  logic                    wr_and, wr_or;
  logic [N_TERM*AND_W-1:0] and_rows;
  logic [N_OUT*OR_W-1:0]   or_rows;
  logic [N_TERM-1:0]       term_vec;
  logic [DEC_N-1:0]        minterm_vec;
  logic [N_OUT-1:0]        sum_vec;
  logic [N_OUT-1:0]        out_q;

  assign wr_and = cfg_load && cfg_we && !cfg_plane;
  assign wr_or  = cfg_load && cfg_we &&  cfg_plane;

  sop_cfg_store #(
    .N_TERM(N_TERM), .N_OUT(N_OUT), .AND_W(AND_W),
    .OR_W(OR_W), .CFG_W(CFG_W), .ROW_W(ROW_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_and(wr_and), .wr_or(wr_or),
    .row(cfg_row), .data(cfg_data), .and_rows(and_rows), .or_rows(or_rows)
  );

  sop_and_plane #(
    .N_IN(N_IN), .N_TERM(N_TERM), .EMPTY_ZERO(EMPTY_ZERO)
  ) and_i (
    .in_vec(in_vec), .and_rows(and_rows),
    .term_vec(term_vec), .minterm_vec(minterm_vec)
  );

  sop_or_plane #(
    .N_TERM(N_TERM), .N_OUT(N_OUT), .DEC_N(DEC_N), .OR_W(OR_W)
  ) or_i (
    .mode(sop_pkg::mode_e'(mode)), .term_vec(term_vec),
    .minterm_vec(minterm_vec), .or_rows(or_rows), .sum_vec(sum_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        out_q <= '0;
    else if (cfg_load) out_q <= '0;
    else               out_q <= sum_vec;
  end

  assign out_vec = out_q;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2,
  parameter int DEC_N = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             cfg_we,
  input logic [1:0]       mode,
  input logic [N_IN-1:0]  in_vec,
  input logic [DEC_N-1:0] minterm_vec,
  input logic [N_OUT-1:0] out_vec
);

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (out_vec == '0)); // R9

  AST_OFF_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && mode == 2'd3) |=> (out_vec == '0)); // R7

  AST_ONE_MINTERM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(minterm_vec) == 1); // R6

  AST_QUIET_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !$past(cfg_load) && $stable(in_vec) && $stable(mode))
      |=> $stable(out_vec)); // R10

  AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && cfg_we && !$past(cfg_load) && $stable(in_vec) && $stable(mode))
      |=> $stable(out_vec)); // R10

endmodule

bind sop_array sop_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .DEC_N(DEC_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_we(cfg_we),
  .mode(mode), .in_vec(in_vec), .minterm_vec(minterm_vec), .out_vec(out_vec)
);

// File: tb/sop_array_tb_top.sv
module sop_array_tb_top;

  localparam int NI = 4;
  localparam int NT = 8;
  localparam int NO = 2;
  localparam int GR = NT / NO;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  in_vec = '0;
  logic        cfg_load = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_plane = 1'b0;
  logic [2:0]  cfg_row = '0;
  logic [15:0] cfg_data = '0;
  logic [1:0]  out_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int and_m [NT];
  int or_m  [NO];

  always #2.5 clk = ~clk;

  sop_array dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_vec(in_vec),
    .cfg_load(cfg_load), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
    .cfg_row(cfg_row), .cfg_data(cfg_data), .out_vec(out_vec)
  );

  function automatic bit term_val(int row, int inv);
    if (row == 0) return 1'b1;
    for (int i = 0; i < NI; i++) begin
      bit b = ((inv >> i) & 1) != 0;
      if (((row >> (2*i)) & 1) != 0 && !b) return 1'b0;
      if (((row >> (2*i+1)) & 1) != 0 && b) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [1:0] model(int inv, int md, bit load);
    logic [1:0] r = '0;
    if (load) return '0;
    for (int m = 0; m < NO; m++) begin
      bit s = 1'b0;
      case (md)
        0: for (int p = 0; p < NT; p++)
             if (((or_m[m] >> p) & 1) != 0 && term_val(and_m[p], inv)) s = 1'b1;
        1: for (int p = m*GR; p < (m+1)*GR; p++)
             if (term_val(and_m[p], inv)) s = 1'b1;
        2: s = ((or_m[m] >> inv) & 1) != 0;
        default: s = 1'b0;
      endcase
      r[m] = s;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [1:0] exp);
    checks++;
    if (out_vec !== exp) begin
      errors++;
      $display("FAIL %s: out_vec=%b expected %b (mode=%0d in=%0d)", tag, out_vec, exp, mode, in_vec);
    end
  endtask

  // One clock: predict from present stimulus, update model, compare after the edge.
  task automatic step(string tag);
    logic [1:0] exp = model(int'(in_vec), int'(mode), cfg_load);
    if (cfg_load && cfg_we) begin
      if (!cfg_plane && int'(cfg_row) < NT) and_m[cfg_row] = int'(cfg_data[7:0]);
      if (cfg_plane && int'(cfg_row) < NO)  or_m[cfg_row]  = int'(cfg_data);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic wr(bit plane, int row, int data, string tag);
    cfg_load = 1'b1; cfg_we = 1'b1; cfg_plane = plane;
    cfg_row = 3'(row); cfg_data = 16'(data);
    step(tag);
    cfg_we = 1'b0;
  endtask

  task automatic sweep(int md, string tag);
    cfg_load = 1'b0; mode = 2'(md);
    for (int v = 0; v < 16; v++) begin
      in_vec = 4'(v);
      step(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NT; p++) and_m[p] = 0;
    for (int m = 0; m < NO; m++) or_m[m] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", 2'b00);
    rst_n = 1'b1;
    in_vec = 4'd5;
    step("R1 after reset");
    step("R3 empty terms, empty OR rows");

    // AND plane: t0=a&~b, t1=c, t2=b&d, t3=~a&~c, t4=a&b&c&d, t5=a&~a
    wr(0, 0, 'h09, "R9 load quiet");
    wr(0, 1, 'h10, "R9 load quiet");
    wr(0, 2, 'hFF44, "R8 upper bits dropped");
    wr(0, 3, 'h22, "R9 load quiet");
    wr(0, 4, 'h55, "R9 load quiet");
    wr(0, 5, 'h03, "R9 load quiet");
    // OR plane: out0=t0|t1, out1=t1|t2 (t1 shared)
    wr(1, 0, 'h0003, "R9 load quiet");
    wr(1, 1, 'h0006, "R4 load quiet");
    wr(1, 6, 'hFFFF, "R8 out-of-range row");
    cfg_load = 1'b0; mode = 2'd0; in_vec = 4'd4;
    step("R9 first cycle after load");
    sweep(0, "R2 R4 array sweep");
    sweep(1, "R5 fixed-OR sweep");

    // Empty term t6 on out1, inverse literal t3 on out0.
    wr(1, 1, 'h0040, "R9 load quiet");
    wr(1, 0, 'h0008, "R9 load quiet");
    sweep(0, "R3 R2 empty term and inverse literals");

    // Truth tables for full decode: parity and a window.
    wr(1, 0, 'h6996, "R9 load quiet");
    wr(1, 1, 'h00F0, "R9 load quiet");
    sweep(2, "R6 decode sweep");

    // Strobe outside the window must not alter the truth tables.
    cfg_load = 1'b0; cfg_we = 1'b1; cfg_plane = 1'b1; cfg_row = 3'd0; cfg_data = 16'h0000;
    in_vec = 4'd1;
    step("R10 write without load");
    cfg_we = 1'b0;
    sweep(2, "R10 R6 tables unchanged");

    sweep(3, "R7 off mode");

    // Reset clears configuration again.
    rst_n = 1'b0;
    for (int p = 0; p < NT; p++) and_m[p] = 0;
    for (int m = 0; m < NO; m++) or_m[m] = 0;
    @(posedge clk); @(negedge clk);
    check("R1 in reset", 2'b00);
    rst_n = 1'b1;
    mode = 2'd1; in_vec = 4'd9;
    step("R1 R3 cleared config, empty groups");
    step("R3 fixed-OR with empty terms");
    finish_run();
  end

endmodule